// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the two offsets that a FIFO's programmable flags compare against. The empty offset sets the almost-empty threshold and the full offset sets the almost-full threshold. A synchronous master reset loads both offsets with one of two default values. The same reset captures which update method the block uses afterwards. The load input chooses both at once: a high level gives the larger default and the bit-serial method, and a low level gives the smaller default and the word-parallel method.

After master reset, the load input stops acting as a selector and gates access to the offset registers. In serial mode, one bit is taken from the serial input on each enabled write-clock edge. In parallel mode, data-bus words are taken from the write side, and the offsets are read back one word at a time on the read clock. A partial reset returns every internal sequence pointer to its start. It does not disturb the offsets or the chosen method. The FIFO storage and its output drivers belong to neighbouring blocks.

Top module: `flag_offset_prog`

## Requirements
- R1: After the asynchronous reset `rst_ni`, both offsets equal the small default (127), the method is parallel, every sequence pointer is at its start and `rdata_o` is 0.
- R2: On a write-clock edge with `mrs_i` high, both offsets become 1023 with the serial method if `ld_i` is high, or 127 with the parallel method if `ld_i` is low. All other writes at that edge are ignored, and the same edge of the read clock clears `rdata_o` and the read pointer.
- R3: In serial mode, each write-clock edge with `sen_i` high stores `si_i` into a 28-bit chain. Chain bits 0..13 are empty-offset bits 0..13, least significant first, and bits 14..27 are full-offset bits 0..13.
- R4: Serial bits that arrive after all 28 chain positions are filled are ignored until the next master or partial reset.
- R5: In parallel mode, a write-clock edge with `wen_i` and `ld_i` both high writes `wdata_i` into the word at the write pointer, and the pointer then advances. The word order is: word 0 = empty offset bits 8:0, word 1 = empty offset bits 13:9 from `wdata_i[4:0]`, word 2 = full offset bits 8:0, word 3 = full offset bits 13:9 from `wdata_i[4:0]`. Bits 8:5 of a high word are dropped, and after word 3 the pointer wraps to word 0.
- R6: A write with `ld_i` low leaves the offsets unchanged. In serial mode, parallel writes are ignored, and in parallel mode, `sen_i` is ignored.
- R7: A read-clock edge with `ren_i` and `ld_i` both high loads `rdata_o` with the word at the read pointer, using the R5 order with high words zero-extended, and the pointer then advances and wraps. Otherwise `rdata_o` holds its value.
- R8: A write-clock edge with `prs_i` high, and `mrs_i` low, leaves both offsets and the method unchanged. It returns the parallel write pointer, the serial bit position and the read pointer to their start and blocks all writes and reads at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrs_i | input | 1 | Synchronous master reset |
| prs_i | input | 1 | Synchronous partial reset |
| ld_i | input | 1 | Default/method select during master reset, register access gate afterwards |
| wen_i | input | 1 | Parallel write enable |
| sen_i | input | 1 | Serial write enable |
| si_i | input | 1 | Serial data bit |
| wdata_i | input | 9 | Parallel write word |
| ren_i | input | 1 | Read-back enable |
| empty_ofs_o | output | 14 | Empty offset |
| full_ofs_o | output | 14 | Full offset |
| rdata_o | output | 9 | Read-back word |

## Verification
The assertions check these behaviours on every edge:
- a master reset lands on the default selected by the load input;
- a partial reset and a write with the load input low leave the offsets untouched;
- the read word holds when no read is enabled;
- the write and read pointers wrap and restart where they should.

The bench's scenarios are needed for the rest:
- the serial bit order, and the bits ignored once the chain is full;
- the word order and dropped high bits of the parallel sequence;
- the wrap of read-back onto the first word;
- the serial position restarting after a partial reset.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  function automatic int words_per_ofs(int ofs_w, int word_w);
    return (ofs_w + word_w - 1) / word_w;
  endfunction
endpackage

// File: rtl/ofs_wr_ctrl.sv
module ofs_wr_ctrl
  import ofs_pkg::*;
#(
  parameter int NWORDS  = 4,
  parameter int CHAIN_W = 28,
  localparam int PTR_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int SCNT_W = $clog2(CHAIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic              prs_i,
  input  logic              ld_i,
  input  logic              wen_i,
  input  logic              sen_i,
  output logic              ser_we_o,
  output logic [SCNT_W-1:0] ser_idx_o,
  output logic              par_we_o,
  output logic [PTR_W-1:0]  par_idx_o
);
  prog_mode_e        mode_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [PTR_W-1:0]  wptr_q;
  logic              busy_rst;

  assign busy_rst  = mrs_i | prs_i;
  assign ser_we_o  = !busy_rst && (mode_q == PROG_SERIAL) && sen_i
                     && (scnt_q < SCNT_W'(CHAIN_W));
  assign par_we_o  = !busy_rst && (mode_q == PROG_PARALLEL) && wen_i && ld_i;
  assign ser_idx_o = scnt_q;
  assign par_idx_o = wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PROG_PARALLEL;
    end else if (mrs_i) begin
      mode_q <= ld_i ? PROG_SERIAL : PROG_PARALLEL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q <= '0;
    end else if (busy_rst) begin
      scnt_q <= '0;
    end else if (ser_we_o) begin
      scnt_q <= scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
    end else if (busy_rst) begin
      wptr_q <= '0;
    end else if (par_we_o) begin
      wptr_q <= (wptr_q == PTR_W'(NWORDS - 1)) ? '0 : wptr_q + 1'b1;
    end
  end

  // R5: sequence wraps after the last word
  a_r5_wptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_we_o && !busy_rst && wptr_q == PTR_W'(NWORDS - 1)) |=> (wptr_q == '0));

  // R8: both write-side positions restart
  a_r8_wr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_i |=> (wptr_q == '0 && scnt_q == '0));

  // R4: serial position never runs past the chain
  a_r4_scnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scnt_q == SCNT_W'(CHAIN_W) && !busy_rst) |=> (scnt_q == SCNT_W'(CHAIN_W)));
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofs_pkg::*;
#(
  parameter int OFFSET_W = 14,
  parameter int WORD_W   = 9,
  parameter int DEF_LO   = 127,
  parameter int DEF_HI   = 1023,
  localparam int WPO     = words_per_ofs(OFFSET_W, WORD_W),
  localparam int NWORDS  = 2 * WPO,
  localparam int CHAIN_W = 2 * OFFSET_W,
  localparam int PTR_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int SCNT_W  = $clog2(CHAIN_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mrs_load_i,
  input  logic                          def_hi_i,
  input  logic                          ser_we_i,
  input  logic [SCNT_W-1:0]             ser_idx_i,
  input  logic                          si_i,
  input  logic                          par_we_i,
  input  logic [PTR_W-1:0]              par_idx_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [CHAIN_W-1:0]            chain_o,
  output logic [NWORDS-1:0][WORD_W-1:0] words_o
);
  localparam logic [OFFSET_W-1:0] DEF_LO_V = OFFSET_W'(DEF_LO);
  localparam logic [OFFSET_W-1:0] DEF_HI_V = OFFSET_W'(DEF_HI);

  logic [CHAIN_W-1:0] chain_q;
  assign chain_o = chain_q;

  for (genvar b = 0; b < CHAIN_W; b++) begin : g_bit
    localparam int R = b % OFFSET_W;
    localparam int K = (b / OFFSET_W) * WPO + R / WORD_W;
    localparam int J = R % WORD_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[b] <= DEF_LO_V[R];
      end else if (mrs_load_i) begin
        chain_q[b] <= def_hi_i ? DEF_HI_V[R] : DEF_LO_V[R];
      end else if (ser_we_i && ser_idx_i == SCNT_W'(b)) begin
        chain_q[b] <= si_i;
      end else if (par_we_i && par_idx_i == PTR_W'(K)) begin
        chain_q[b] <= wdata_i[J];
      end
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    for (genvar j = 0; j < WORD_W; j++) begin : g_wbit
      localparam int R = (k % WPO) * WORD_W + j;
      if (R < OFFSET_W) begin : g_live
        assign words_o[k][j] = chain_q[(k / WPO) * OFFSET_W + R];
      end else begin : g_pad
        assign words_o[k][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 9,
  localparam int PTR_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mrs_i,
  input  logic                          prs_i,
  input  logic                          ld_i,
  input  logic                          ren_i,
  input  logic [NWORDS-1:0][WORD_W-1:0] words_i,
  output logic [WORD_W-1:0]             rdata_o
);
  logic [PTR_W-1:0]  rptr_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rd_en;

  assign rd_en   = ren_i && ld_i && !mrs_i && !prs_i;
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rdata_q <= '0;
    end else if (mrs_i) begin
      rptr_q  <= '0;
      rdata_q <= '0;
    end else if (prs_i) begin
      rptr_q  <= '0;
    end else if (rd_en) begin
      rdata_q <= words_i[rptr_q];
      rptr_q  <= (rptr_q == PTR_W'(NWORDS - 1)) ? '0 : rptr_q + 1'b1;
    end
  end

  // R7: output word only moves on an enabled read or master reset
  a_r7_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mrs_i && !(ren_i && ld_i)) |=> $stable(rdata_q));

  // R8: read sequence restarts on either reset
  a_r8_rd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_i || prs_i) |=> (rptr_q == '0));
endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import ofs_pkg::*;
#(
  parameter int OFFSET_W = 14,
  parameter int WORD_W   = 9,
  parameter int DEF_LO   = 127,
  parameter int DEF_HI   = 1023
) (
  input  logic                wclk_i,
  input  logic                rclk_i,
  input  logic                rst_ni,
  input  logic                mrs_i,
  input  logic                prs_i,
  input  logic                ld_i,
  input  logic                wen_i,
  input  logic                sen_i,
  input  logic                si_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                ren_i,
  output logic [OFFSET_W-1:0] empty_ofs_o,
  output logic [OFFSET_W-1:0] full_ofs_o,
  output logic [WORD_W-1:0]   rdata_o
);
  localparam int WPO     = words_per_ofs(OFFSET_W, WORD_W);
  localparam int NWORDS  = 2 * WPO;
  localparam int CHAIN_W = 2 * OFFSET_W;
  localparam int PTR_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int SCNT_W  = $clog2(CHAIN_W + 1);
  localparam logic [OFFSET_W-1:0] DEF_LO_V = OFFSET_W'(DEF_LO);
  localparam logic [OFFSET_W-1:0] DEF_HI_V = OFFSET_W'(DEF_HI);

  logic                          ser_we, par_we;
  logic [SCNT_W-1:0]             ser_idx;
  logic [PTR_W-1:0]              par_idx;
  logic [CHAIN_W-1:0]            chain;
  logic [NWORDS-1:0][WORD_W-1:0] words;

  ofs_wr_ctrl #(.NWORDS(NWORDS), .CHAIN_W(CHAIN_W)) i_wr_ctrl (
    .clk_i    (wclk_i),
    .rst_ni   (rst_ni),
    .mrs_i    (mrs_i),
    .prs_i    (prs_i),
    .ld_i     (ld_i),
    .wen_i    (wen_i),
    .sen_i    (sen_i),
    .ser_we_o (ser_we),
    .ser_idx_o(ser_idx),
    .par_we_o (par_we),
    .par_idx_o(par_idx)
  );

  ofs_store #(
    .OFFSET_W(OFFSET_W), .WORD_W(WORD_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) i_store (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .mrs_load_i(mrs_i),
    .def_hi_i  (ld_i),
    .ser_we_i  (ser_we),
    .ser_idx_i (ser_idx),
    .si_i      (si_i),
    .par_we_i  (par_we),
    .par_idx_i (par_idx),
    .wdata_i   (wdata_i),
    .chain_o   (chain),
    .words_o   (words)
  );

  ofs_rd_port #(.NWORDS(NWORDS), .WORD_W(WORD_W)) i_rd_port (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .mrs_i  (mrs_i),
    .prs_i  (prs_i),
    .ld_i   (ld_i),
    .ren_i  (ren_i),
    .words_i(words),
    .rdata_o(rdata_o)
  );

  assign empty_ofs_o = chain[OFFSET_W-1:0];
  assign full_ofs_o  = chain[CHAIN_W-1:OFFSET_W];

  // R2: master reset lands on the selected default pair
  a_r2_mrs_default: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    mrs_i |=> (empty_ofs_o == ($past(ld_i) ? DEF_HI_V : DEF_LO_V)
               && full_ofs_o == ($past(ld_i) ? DEF_HI_V : DEF_LO_V)));

  // R8: partial reset keeps the programmed offsets
  a_r8_prs_keeps: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (prs_i && !mrs_i) |=> $stable({full_ofs_o, empty_ofs_o}));

  // R6: no write reaches the offsets with the gate low and no serial enable
  a_r6_gate_low: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!mrs_i && !ld_i && !sen_i) |=> $stable({full_ofs_o, empty_ofs_o}));

  // R4: a filled chain ignores further serial bits
  a_r4_tail_ignored: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!mrs_i && !prs_i && !par_we && ser_idx == SCNT_W'(CHAIN_W))
      |=> $stable({full_ofs_o, empty_ofs_o}));
endmodule

// File: tb/test_flag_offset_prog.sv
module test_flag_offset_prog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs = 0, prs = 0, ld = 0, wen = 0, sen = 0, si = 0, ren = 0;
  logic [8:0]  wdata = '0;
  logic [13:0] empty_ofs, full_ofs;
  logic [8:0]  rdata;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  flag_offset_prog i_flag_offset_prog (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .mrs_i(mrs), .prs_i(prs), .ld_i(ld), .wen_i(wen), .sen_i(sen),
    .si_i(si), .wdata_i(wdata), .ren_i(ren),
    .empty_ofs_o(empty_ofs), .full_ofs_o(full_ofs), .rdata_o(rdata)
  );

  // behavioural reference
  logic [13:0] m_emp, m_ful;
  logic [8:0]  m_rd;
  bit          m_ser;
  int          m_wp, m_rp, m_sc;

  function automatic logic [8:0] m_word(int k);
    case (k)
      0:       return m_emp[8:0];
      1:       return {4'b0, m_emp[13:9]};
      2:       return m_ful[8:0];
      default: return {4'b0, m_ful[13:9]};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_emp = 14'd127; m_ful = 14'd127; m_rd = '0;
      m_ser = 0; m_wp = 0; m_rp = 0; m_sc = 0;
    end else if (mrs) begin
      m_emp = ld ? 14'd1023 : 14'd127;
      m_ful = m_emp;
      m_ser = ld; m_wp = 0; m_rp = 0; m_sc = 0; m_rd = '0;
    end else if (prs) begin
      m_wp = 0; m_rp = 0; m_sc = 0;
    end else begin
      if (ren && ld) begin
        m_rd = m_word(m_rp);
        m_rp = (m_rp + 1) % 4;
      end
      if (m_ser) begin
        if (sen && m_sc < 28) begin
          if (m_sc < 14) m_emp[m_sc] = si;
          else           m_ful[m_sc-14] = si;
          m_sc++;
        end
      end else if (wen && ld) begin
        case (m_wp)
          0: m_emp[8:0]  = wdata;
          1: m_emp[13:9] = wdata[4:0];
          2: m_ful[8:0]  = wdata;
          default: m_ful[13:9] = wdata[4:0];
        endcase
        m_wp = (m_wp + 1) % 4;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " empty model"}, empty_ofs, m_emp);
      chk({cur_req, " full model"},  full_ofs,  m_ful);
      chk({cur_req, " rdata model"}, rdata,     m_rd);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    mrs = 0; prs = 0; ld = 0; wen = 0; sen = 0; si = 0; ren = 0; wdata = '0;
  endtask

  task automatic ser_load(logic [13:0] e, logic [13:0] f);
    for (int i = 0; i < 28; i++) begin
      sen = 1; si = (i < 14) ? e[i] : f[i-14];
      tick();
    end
    sen = 0; si = 0;
  endtask

  task automatic pwrite(logic [8:0] d);
    ld = 1; wen = 1; wdata = d; tick();
    wen = 0; ld = 0;
  endtask

  task automatic pread();
    ld = 1; ren = 1; tick();
    ren = 0; ld = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: defaults after asynchronous reset
    chk("R1 empty", empty_ofs, 127);
    chk("R1 full", full_ofs, 127);
    chk("R1 rdata", rdata, 0);
    cur_req = "R1";
    pwrite(9'h055);
    chk("R1 parallel method", empty_ofs, 14'h0055);

    // R2: master reset with load high
    cur_req = "R2";
    mrs = 1; ld = 1; tick(); idle();
    chk("R2 empty 1023", empty_ofs, 1023);
    chk("R2 full 1023", full_ofs, 1023);

    // R3: serial chain
    cur_req = "R3";
    ser_load(14'h2A5C, 14'h1337);
    chk("R3 serial empty", empty_ofs, 14'h2A5C);
    chk("R3 serial full", full_ofs, 14'h1337);

    // R4: extra bits dropped
    cur_req = "R4";
    for (int i = 0; i < 3; i++) begin sen = 1; si = 1; tick(); end
    idle();
    chk("R4 tail empty", empty_ofs, 14'h2A5C);
    chk("R4 tail full", full_ofs, 14'h1337);

    // R6: parallel write ignored in serial mode
    cur_req = "R6";
    pwrite(9'h1FF);
    chk("R6 serial mode par write", empty_ofs, 14'h2A5C);

    // R7: read-back order and wrap
    cur_req = "R7";
    pread(); chk("R7 word0", rdata, 9'h05C);
    pread(); chk("R7 word1", rdata, 9'h015);
    pread(); chk("R7 word2", rdata, 9'h137);
    pread(); chk("R7 word3", rdata, 9'h009);
    pread(); chk("R7 wrap", rdata, 9'h05C);
    ren = 1; tick(); idle();
    chk("R7 hold without ld", rdata, 9'h05C);

    // R8: partial reset
    cur_req = "R8";
    prs = 1; tick(); idle();
    chk("R8 empty kept", empty_ofs, 14'h2A5C);
    chk("R8 full kept", full_ofs, 14'h1337);
    pread(); chk("R8 read restart", rdata, 9'h05C);
    sen = 1; si = 1; tick(); idle();
    chk("R8 serial restart", empty_ofs, 14'h2A5D);

    // R2: master reset with load low
    cur_req = "R2";
    mrs = 1; ld = 0; tick(); idle();
    chk("R2 empty 127", empty_ofs, 127);
    chk("R2 rdata cleared", rdata, 0);

    // R6: serial and ungated writes ignored in parallel mode
    cur_req = "R6";
    sen = 1; si = 1; tick(); idle();
    wen = 1; wdata = 9'h1AA; tick(); idle();
    chk("R6 ignored empty", empty_ofs, 127);
    chk("R6 ignored full", full_ofs, 127);

    // R5: parallel sequence
    cur_req = "R5";
    pwrite(9'h1A3); pwrite(9'h1FF); pwrite(9'h0F0); pwrite(9'h0E2);
    chk("R5 empty", empty_ofs, 14'h3FA3);
    chk("R5 full", full_ofs, 14'h04F0);
    pwrite(9'h011);
    chk("R5 wrap", empty_ofs, 14'h3E11);

    // R2: master reset wins over a simultaneous write
    cur_req = "R2";
    mrs = 1; ld = 1; wen = 1; wdata = 9'h000; tick(); idle();
    chk("R2 priority", empty_ofs, 1023);
    chk("R2 priority full", full_ofs, 1023);

    repeat (2) tick();
    finish_run();
  end
endmodule